// File: doc/BRIEF.md
# Multi-Channel Timer Wrapper with Shared Run Control

This block gathers up to eight simple timer channels behind one register-mapped bus slave. A presence mask, fixed at build time, selects which physical channel slots exist. Only those slots are built. The remaining slots stay holes in the address map. The block decodes bus addresses into per-channel register blocks. It keeps a run register with one bit per physical slot and a clock-enable register that gates each slot's count tick. Each channel's interrupt comes out on its own output line, and an OR of all lines is also provided.

Run-bit and block positions always follow the physical slot number. The per-channel outputs are packed by logical index: logical output k belongs to the k-th present slot, counted from slot 0 upward. A build parameter selects one of two layouts. In the grouped layout, one run register holds the bits of all channels. In the spread layout, each channel has its own run register inside its own address window. A change of a run bit reaches the counter two clocks after the bus write.

Each channel is a minimal counter stub with three registers. The control register carries a match flag and an interrupt enable. The counter counts up on every enabled tick. The compare register holds the value at which the counter wraps to zero and sets the flag.

Top module: `tmr_wrap`

## Requirements
- R1: After reset, every run bit and every clock-enable bit is 0, `run_o` and `irq_any_o` are 0, and every present channel's compare register reads all ones.
- R2: In the grouped layout, the run register is at byte address 0x000, and bit n controls physical slot n. Its readback shows only the bits of present slots; the bits of absent slots read 0.
- R3: A write that sets or clears a run bit changes the matching `run_o` bit on the third rising edge counted from the edge that takes the write. In the bench, this is two falling edges after the write cycle.
- R4: The clock-enable register is at byte address 0x1000, with bit n for physical slot n, and absent bits read 0. A running slot whose enable bit is 0 does not count while `tick_i` is high, and its `ch_tick_o` bit stays 0.
- R5: In the grouped layout, slot n's block starts at byte address 0x10 + 0x10*n. Offset +0x0 holds control, +0x4 holds the counter and +0x8 holds the compare value.
- R6: Reads from an absent slot's registers, from block offset +0xC, or from any unmapped address return 0. Writes to those addresses change nothing that can be read back.
- R7: Bit k of `run_o`, `ch_tick_o` and `irq_o` belongs to the k-th set bit of the presence mask, counted from bit 0 upward.
- R8: On each cycle with an enabled tick, a running counter adds 1. If the counter already equals the compare value, it goes to 0 instead and the match flag (control bit 0) is set. Writing 1 to control bit 0 clears the flag.
- R9: `irq_o[k]` is high when the channel's match flag and its interrupt enable (control bit 1) are both 1. `irq_any_o` is the OR of all channel interrupts.
- R10: In the spread layout, slot n's run register is at 0x100*n, with the run bit at bit 0, and its block starts at 0x100*n + 0x10. The grouped-layout addresses other than 0x1000 are not mapped.
- R11: Read data appears on `bus_rdata` after the rising edge that takes `bus_rd`, and it holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 13 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_i | input | 1 | Common count tick strobe |
| run_o | output | NUM_CH | Effective run state per logical channel |
| ch_tick_o | output | NUM_CH | Gated tick reaching each logical channel |
| irq_o | output | NUM_CH | Interrupt per logical channel |
| irq_any_o | output | 1 | OR of all channel interrupts |

## Verification
The hardest case to reach from the ports is a channel that is running but receives no ticks because its clock-enable bit is 0. Its counter must stay put while its neighbours count. The stimulus enables only some present slots, starts every slot, and then pulses the tick. Counter readback and `ch_tick_o` then show which slots moved. The stimulus also wraps one channel with a small compare value to raise its interrupt. It places writes on absent slots and reserved words, and it repeats the run-bit timing check on a second instance built with the spread layout.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int MAX_CH  = 8;
    localparam int ADDR_W  = 13;
    localparam int DATA_W  = 32;
    localparam int RUN_LAG = 2;

    localparam logic [ADDR_W-1:0] CLKEN_ADDR = 13'h1000;

    typedef enum logic [1:0] {
        HIT_NONE  = 2'd0,
        HIT_START = 2'd1,
        HIT_CLKEN = 2'd2,
        HIT_CHAN  = 2'd3
    } hit_e;

    typedef enum logic [1:0] {
        W_CTRL  = 2'd0,
        W_COUNT = 2'd1,
        W_CMP   = 2'd2,
        W_RSVD  = 2'd3
    } word_e;

    typedef struct packed {
        hit_e       hit;
        logic [2:0] ch;
        word_e      word;
    } dec_t;

    function automatic int popcnt(input logic [MAX_CH-1:0] m);
        int n;
        n = 0;
        for (int i = 0; i < MAX_CH; i++) begin
            if (m[i]) n++;
        end
        return n;
    endfunction

    function automatic int phys_of(input logic [MAX_CH-1:0] m, input int k);
        int seen;
        int res;
        seen = 0;
        res  = 0;
        for (int i = 0; i < MAX_CH; i++) begin
            if (m[i]) begin
                if (seen == k) res = i;
                seen++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec
    import tmr_pkg::*;
#(
    parameter logic [MAX_CH-1:0] PRESENT = 8'h65,
    parameter bit                PER_CH  = 1'b0
) (
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);

    logic [3:0] blk_sel;
    logic [2:0] ch_sel;
    logic [7:0] off;

    always_comb begin
        dec_o   = '{hit: HIT_NONE, ch: 3'd0, word: W_CTRL};
        blk_sel = addr_i[7:4] - 4'd1;
        ch_sel  = addr_i[10:8];
        off     = addr_i[7:0];
        if (addr_i == CLKEN_ADDR) begin
            dec_o.hit = HIT_CLKEN;
        end else if (!PER_CH) begin
            if (addr_i == '0) begin
                dec_o.hit = HIT_START;
            end else if (addr_i[ADDR_W-1:8] == '0 && addr_i[7:4] != 4'd0
                         && !blk_sel[3] && addr_i[1:0] == 2'd0
                         && addr_i[3:2] != 2'd3 && PRESENT[blk_sel[2:0]]) begin
                dec_o.hit  = HIT_CHAN;
                dec_o.ch   = blk_sel[2:0];
                dec_o.word = word_e'(addr_i[3:2]);
            end
        end else if (addr_i[ADDR_W-1:11] == '0 && PRESENT[ch_sel]) begin
            if (off == 8'h00) begin
                dec_o.hit = HIT_START;
                dec_o.ch  = ch_sel;
            end else if (off[7:4] == 4'h1 && off[1:0] == 2'd0 && off[3:2] != 2'd3) begin
                dec_o.hit  = HIT_CHAN;
                dec_o.ch   = ch_sel;
                dec_o.word = word_e'(off[3:2]);
            end
        end
    end

endmodule

// File: rtl/tmr_run_ctl.sv
module tmr_run_ctl
    import tmr_pkg::*;
#(
    parameter logic [MAX_CH-1:0] PRESENT = 8'h65,
    parameter bit                PER_CH  = 1'b0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              wr_i,
    input  dec_t              dec_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [MAX_CH-1:0] start_q,
    output logic [MAX_CH-1:0] clken_q,
    output logic [MAX_CH-1:0] run_o
);

    logic [MAX_CH-1:0] lag_q [RUN_LAG];
    logic              unused_bits;

    assign unused_bits = ^{wdata_i[DATA_W-1:MAX_CH], dec_i.word};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            start_q <= '0;
            clken_q <= '0;
            for (int i = 0; i < RUN_LAG; i++) lag_q[i] <= '0;
        end else begin
            if (wr_i && dec_i.hit == HIT_START) begin
                if (PER_CH) start_q[dec_i.ch] <= wdata_i[0];
                else        start_q <= wdata_i[MAX_CH-1:0] & PRESENT;
            end
            if (wr_i && dec_i.hit == HIT_CLKEN)
                clken_q <= wdata_i[MAX_CH-1:0] & PRESENT;
            lag_q[0] <= start_q;
            for (int i = 1; i < RUN_LAG; i++) lag_q[i] <= lag_q[i-1];
        end
    end

    assign run_o = lag_q[RUN_LAG-1];

    // R3: the effective run state moves only as a consequence of a run-register write
    p_run_follows_write_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (run_o != $past(run_o)) |-> $past(wr_i && dec_i.hit == HIT_START, RUN_LAG + 1));

    // R2: bits of absent slots never hold a run or enable value
    p_absent_bits_clear_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        ((start_q | clken_q) & ~PRESENT) == '0);

endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              tick_i,
    input  logic              wr_i,
    input  word_e             word_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              irq_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic             flag_q;
    logic             ie_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= '0;
            cmp_q  <= '1;
            flag_q <= 1'b0;
            ie_q   <= 1'b0;
        end else begin
            if (tick_i) begin
                if (cnt_q == cmp_q) begin
                    cnt_q  <= '0;
                    flag_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            if (wr_i) begin
                case (word_i)
                    W_CTRL: begin
                        ie_q <= wdata_i[1];
                        if (wdata_i[0]) flag_q <= 1'b0;
                    end
                    W_COUNT: cnt_q <= wdata_i[CNT_W-1:0];
                    W_CMP:   cmp_q <= wdata_i[CNT_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (word_i)
            W_CTRL:  rdata_o = {{(DATA_W-2){1'b0}}, ie_q, flag_q};
            W_COUNT: rdata_o = DATA_W'(cnt_q);
            W_CMP:   rdata_o = DATA_W'(cmp_q);
            default: rdata_o = '0;
        endcase
    end

    assign cnt_o = cnt_q;
    assign irq_o = flag_q & ie_q;

    // R8: without a tick or a counter write the count holds
    p_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (!tick_i && !(wr_i && word_i == W_COUNT)) |=> $stable(cnt_q));

    // R8: a tick at the compare value wraps to zero and raises the flag
    p_wrap_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (tick_i && !wr_i && cnt_q == cmp_q) |=> (cnt_q == '0 && flag_q));

endmodule

// File: rtl/tmr_wrap.sv
module tmr_wrap
    import tmr_pkg::*;
#(
    parameter logic [MAX_CH-1:0] PRESENT      = 8'h65,
    parameter bit                PER_CH_START = 1'b0,
    parameter int                CNT_W        = 32,
    parameter int                NUM_CH       = tmr_pkg::popcnt(PRESENT)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_i,
    output logic [NUM_CH-1:0] run_o,
    output logic [NUM_CH-1:0] ch_tick_o,
    output logic [NUM_CH-1:0] irq_o,
    output logic              irq_any_o
);

    dec_t              dec;
    logic [MAX_CH-1:0] start_q;
    logic [MAX_CH-1:0] clken_q;
    logic [MAX_CH-1:0] run_phys;
    logic [MAX_CH-1:0] ch_tick;
    logic [MAX_CH-1:0] chan_wr;
    logic [MAX_CH-1:0] chan_irq;
    logic [DATA_W-1:0] chan_rd  [MAX_CH];
    logic [CNT_W-1:0]  chan_cnt [MAX_CH];
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;

    tmr_addr_dec #(.PRESENT(PRESENT), .PER_CH(PER_CH_START)) u_dec (
        .addr_i (bus_addr),
        .dec_o  (dec)
    );

    tmr_run_ctl #(.PRESENT(PRESENT), .PER_CH(PER_CH_START)) u_run (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wr_i    (bus_wr),
        .dec_i   (dec),
        .wdata_i (bus_wdata),
        .start_q (start_q),
        .clken_q (clken_q),
        .run_o   (run_phys)
    );

    for (genvar p = 0; p < MAX_CH; p++) begin : g_slot
        assign ch_tick[p] = tick_i & run_phys[p] & clken_q[p];
        assign chan_wr[p] = bus_wr && dec.hit == HIT_CHAN && dec.ch == 3'(p);
        if (PRESENT[p]) begin : g_on
            tmr_chan #(.CNT_W(CNT_W)) u_ch (
                .clk_i   (clk_i),
                .rst_i   (rst_i),
                .tick_i  (ch_tick[p]),
                .wr_i    (chan_wr[p]),
                .word_i  (dec.word),
                .wdata_i (bus_wdata),
                .rdata_o (chan_rd[p]),
                .cnt_o   (chan_cnt[p]),
                .irq_o   (chan_irq[p])
            );

            // R4: a slot without clock enable keeps its count unless written
            p_gate_r4: assert property (@(posedge clk_i) disable iff (rst_i)
                (!clken_q[p] && !chan_wr[p]) |=> $stable(chan_cnt[p]));
        end else begin : g_off
            assign chan_rd[p]  = '0;
            assign chan_cnt[p] = '0;
            assign chan_irq[p] = 1'b0;
        end
    end

    for (genvar k = 0; k < NUM_CH; k++) begin : g_log
        localparam int P = tmr_pkg::phys_of(PRESENT, k);
        assign run_o[k]     = run_phys[P];
        assign ch_tick_o[k] = ch_tick[P];
        assign irq_o[k]     = chan_irq[P];
    end

    assign irq_any_o = |chan_irq;

    always_comb begin
        case (dec.hit)
            HIT_START: rd_mux = PER_CH_START ? DATA_W'(start_q[dec.ch]) : DATA_W'(start_q);
            HIT_CLKEN: rd_mux = DATA_W'(clken_q);
            HIT_CHAN:  rd_mux = chan_rd[dec.ch];
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i)       rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    // R6: an access that decodes to nothing returns zero
    p_unmapped_zero_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_rd && dec.hit == HIT_NONE) |=> (bus_rdata == '0));

    // R11: read data only moves on a read
    p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/sim_tmr_wrap.sv
`timescale 1ns/1ps
module sim_tmr_wrap;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr0 = 1'b0, rd0 = 1'b0, wr1 = 1'b0, rd1 = 1'b0;
    logic [12:0] addr = '0;
    logic [31:0] wdata = '0;
    logic        tick = 1'b0;
    logic [31:0] rdata0, rdata1;
    logic [3:0]  run0, run1, ctk0, ctk1, irq0, irq1;
    logic        any0, any1;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    bit          inst_q [$];
    logic        rd_p0 = 1'b0, rd_p1 = 1'b0;

    always #2.5 clk = ~clk;

    tmr_wrap #(.PRESENT(8'h65), .PER_CH_START(1'b0)) u0 (
        .clk_i(clk), .rst_i(rst), .bus_wr(wr0), .bus_rd(rd0), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata0), .tick_i(tick), .run_o(run0),
        .ch_tick_o(ctk0), .irq_o(irq0), .irq_any_o(any0));

    tmr_wrap #(.PRESENT(8'h65), .PER_CH_START(1'b1)) u1 (
        .clk_i(clk), .rst_i(rst), .bus_wr(wr1), .bus_rd(rd1), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata1), .tick_i(tick), .run_o(run1),
        .ch_tick_o(ctk1), .irq_o(irq1), .irq_any_o(any1));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input bit inst, input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (inst) wr1 = 1'b1; else wr0 = 1'b1;
        @(negedge clk);
        wr0 = 1'b0; wr1 = 1'b0;
    endtask

    task automatic bus_read(input bit inst, input logic [12:0] a, input logic [31:0] e,
                            input string tag);
        @(negedge clk);
        addr = a;
        if (inst) rd1 = 1'b1; else rd0 = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag); inst_q.push_back(inst);
        @(negedge clk);
        rd0 = 1'b0; rd1 = 1'b0;
    endtask

    task automatic pulse_ticks(input int n, input logic [3:0] exp_ctk, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            #1 check(tag, 32'(ctk0), 32'(exp_ctk));
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    // scoreboard monitor
    always @(posedge clk) begin
        rd_p0 <= rd0;
        rd_p1 <= rd1;
    end

    always @(negedge clk) begin
        if (rd_p0 || rd_p1) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11 unexpected read result got %h expected none", rdata0);
            end else begin
                logic [31:0] e;
                string t;
                bit s;
                e = exp_q.pop_front(); t = tag_q.pop_front(); s = inst_q.pop_front();
                check(t, s ? rdata1 : rdata0, e);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired got hang expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 run_o", 32'(run0), 32'h0);
        check("R1 irq_any", 32'(any0), 32'h0);
        bus_read(0, 13'h000, 32'h0, "R1 run register");
        bus_read(0, 13'h1000, 32'h0, "R1 clock enable");
        bus_read(0, 13'h018, 32'hFFFF_FFFF, "R1 R5 compare slot0");

        // R2 / R3 start all
        bus_write(0, 13'h000, 32'hFF);
        check("R3 run after 0 edges", 32'(run0), 32'h0);
        @(negedge clk);
        check("R3 run after 1 edge", 32'(run0), 32'h0);
        @(negedge clk);
        check("R3 R7 run after 2 edges", 32'(run0), 32'hF);
        bus_read(0, 13'h000, 32'h65, "R2 run readback masked");

        // R4 clock enable slots 0 and 5
        bus_write(0, 13'h1000, 32'h21);
        bus_read(0, 13'h1000, 32'h21, "R4 enable readback");
        pulse_ticks(3, 4'b0101, "R4 R7 ch_tick pattern");
        bus_read(0, 13'h014, 32'd3, "R5 R8 slot0 count");
        bus_read(0, 13'h034, 32'd0, "R4 slot2 gated count");
        bus_read(0, 13'h064, 32'd3, "R5 R8 slot5 count");
        bus_read(0, 13'h074, 32'd0, "R4 slot6 gated count");

        // R6 absent slot and reserved word
        bus_write(0, 13'h024, 32'd5);
        bus_read(0, 13'h024, 32'd0, "R6 absent slot1 count");
        bus_read(0, 13'h01C, 32'd0, "R6 reserved word");
        bus_read(0, 13'h0A0, 32'd0, "R6 unmapped address");

        // R8 / R9 wrap on slot5
        bus_write(0, 13'h068, 32'd2);
        bus_write(0, 13'h064, 32'd0);
        bus_write(0, 13'h060, 32'h2);
        check("R9 irq before wrap", 32'(irq0), 32'h0);
        pulse_ticks(3, 4'b0101, "R8 ticks");
        check("R9 R7 irq slot5", 32'(irq0), 32'b0100);
        check("R9 irq_any", 32'(any0), 32'h1);
        bus_read(0, 13'h060, 32'h3, "R8 flag and enable");
        bus_read(0, 13'h064, 32'd0, "R8 wrapped count");
        bus_write(0, 13'h060, 32'h3);
        check("R8 W1C irq cleared", 32'(irq0), 32'h0);
        bus_read(0, 13'h060, 32'h2, "R8 flag cleared");

        // R3 stop all but slot0
        bus_write(0, 13'h000, 32'h01);
        check("R3 stop after 0 edges", 32'(run0), 32'hF);
        @(negedge clk);
        check("R3 stop after 1 edge", 32'(run0), 32'hF);
        @(negedge clk);
        check("R3 stop after 2 edges", 32'(run0), 32'b0001);

        // R10 spread layout on u1
        bus_write(1, 13'h1000, 32'hFF);
        bus_write(1, 13'h500, 32'h1);
        check("R10 R3 u1 run early", 32'(run1), 32'h0);
        @(negedge clk);
        check("R10 R3 u1 run 1 edge", 32'(run1), 32'h0);
        @(negedge clk);
        check("R10 R7 u1 run slot5", 32'(run1), 32'b0100);
        bus_read(1, 13'h1000, 32'h65, "R10 R4 u1 enable masked");
        bus_read(1, 13'h500, 32'h1, "R10 slot5 run bit");
        bus_read(1, 13'h000, 32'h0, "R10 slot0 run bit");
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        @(negedge clk);
        tick = 1'b0;
        bus_read(1, 13'h514, 32'd2, "R10 slot5 count");
        bus_read(1, 13'h014, 32'd0, "R10 slot0 idle count");
        bus_write(1, 13'h100, 32'h1);
        bus_read(1, 13'h100, 32'h0, "R10 R6 absent slot1 run");
        bus_read(1, 13'h064, 32'h0, "R10 grouped address unmapped");

        repeat (3) @(negedge clk);
        check("R11 scoreboard drained", 32'(exp_q.size()), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule